// File: doc/BRIEF.md
# Retriggerable One-Shot Timer Channel

This block is a single timer channel working as a retriggerable one-shot. Software programs a reload count, picks whether the trigger comes from a write strobe or from an external pin, and sets a run bit. Once running, an accepted trigger drives the output high. The counter then steps down once per count-source enable tick. When the count runs out, the output drops and an interrupt request flag is raised. The counter reloads and the channel waits for the next trigger.

A trigger that lands while the output is already high restarts the pulse. The counter takes one more decrement and reloads on the following tick, so the output never drops. Clearing the run bit aborts any pulse: the output goes low, the counter reloads, and the interrupt flag rises one clock later. Moving the channel into one-shot mode from timer or event-counter mode also raises the flag. A shutdown input can force the output driver to high impedance when software has enabled that cutoff.

Top module: `oneshot_chan`

## Requirements
- R1: After reset the output is low, the output enable is 1, the interrupt flag is 0 and the counter reads 0.
- R2: Writes to mode, reload value, trigger select and cutoff enable take effect only while the run bit is 0. While it is 1 they are ignored, and the counter keeps its value.
- R3: A trigger is taken only while running in one-shot mode (mode code 2). Trigger select 0 takes `sw_trig`, and 1 takes a rising edge on `ext_trig`. The unselected source, triggers while stopped, and triggers in any other mode have no effect.
- R4: The output rises on the first tick at or after the trigger. A tick in the same cycle as the trigger counts, so the output is high one clock after the trigger strobe.
- R5: With reload value N, an un-retriggered pulse lasts N ticks, and a value of 0 behaves like 1. The output falls on the tick where the counter steps from 1 to 0, and the counter reads N again afterwards.
- R6: The interrupt flag is set in the same clock as the output falls at count expiry.
- R7: A retrigger accepted on the k-th tick after the previous accepted trigger decrements once more, reloads on the next tick and keeps counting. The pulse lasts k+1+N ticks in total.
- R8: A retrigger arriving on the tick right after an accepted trigger (k=1) is dropped, and the pulse stays N ticks.
- R9: Clearing the run bit while running forces the output low and loads the reload value into the counter at the same edge. The interrupt flag is set one clock later.
- R10: Writing mode 2 while the current mode is 0 (timer) or 1 (event counter) sets the interrupt flag one clock after the write. Writing 2 from mode 3 or from mode 2 does not.
- R11: The interrupt flag stays set until an `irq_clr` strobe. A set and a clear in the same clock leave it set.
- R12: `ext_trig` is synchronised through two flops and only its rising edge triggers. A level held high gives exactly one pulse.
- R13: With cutoff enabled and `shdn_n` low, `pin_oe` is 0 three clocks after `shdn_n` falls. It returns to 1 once `shdn_n` is high again. With cutoff disabled, `pin_oe` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-source enable, one clock wide |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code: 0 timer, 1 event, 2 one-shot, 3 PWM |
| cfg_reload | input | CW | Reload value |
| cfg_ext_sel | input | 1 | Trigger select, 1 = external pin |
| cfg_cut_en | input | 1 | Enables the shutdown cutoff |
| run_we | input | 1 | Run-bit write strobe |
| run_val | input | 1 | Run-bit value written |
| sw_trig | input | 1 | Software trigger strobe |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| shdn_n | input | 1 | Active-low shutdown pin, asynchronous |
| pin_o | output | 1 | Timer output value |
| pin_oe | output | 1 | Output enable, 0 = high impedance |
| irq_o | output | 1 | Interrupt request flag |
| cnt_o | output | CW | Current counter value |

## Verification
The counter is visible on `cnt_o`, and every pulse length is measured in ticks at `pin_o`. A wrong reload, a lost retrigger or an extra decrement therefore shows as a pulse one or more ticks off, by the end of that pulse at the latest. Retrigger timing is probed at the boundary between the dropped case (k=1) and the accepted cases (k=2 and k=3). Interrupt sources are told apart by their timing: expiry sets the flag in the same clock as the output falls, while a stop or a mode entry sets it one clock later. A flag raised by the wrong source, or in the wrong clock, shows at `irq_o` within two clocks of the event.

// File: rtl/os_pkg.sv
package os_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_PWM     = 2'd3
  } os_mode_e;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= RST_VAL;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/os_cfg.sv
module os_cfg import os_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_reload,
  input  logic          cfg_ext_sel,
  input  logic          cfg_cut_en,
  input  logic          run_we,
  input  logic          run_val,
  output os_mode_e      mode_q,
  output logic [CW-1:0] reload_q,
  output logic          ext_sel_q,
  output logic          cut_en_q,
  output logic          run_q,
  output logic          ld_p,
  output logic          stop_p,
  output logic          entry_q
);
  os_mode_e new_mode;
  logic     entry_d;

  assign new_mode = os_mode_e'(cfg_mode);
  assign ld_p     = cfg_we & ~run_q;
  assign stop_p   = run_we & ~run_val & run_q;
  assign entry_d  = ld_p && (new_mode == MODE_ONESHOT) &&
                    ((mode_q == MODE_TIMER) || (mode_q == MODE_EVENT));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_TIMER;
      reload_q  <= '0;
      ext_sel_q <= 1'b0;
      cut_en_q  <= 1'b0;
      run_q     <= 1'b0;
      entry_q   <= 1'b0;
    end else begin
      entry_q <= entry_d;
      if (ld_p) begin
        mode_q    <= new_mode;
        reload_q  <= cfg_reload;
        ext_sel_q <= cfg_ext_sel;
        cut_en_q  <= cfg_cut_en;
      end
      if (run_we) run_q <= run_val;
    end
  end
endmodule

// File: rtl/os_core.sv
module os_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          os_en,
  input  logic          trig_ev,
  input  logic          stop_p,
  input  logic          ld_p,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] reload_q,
  output logic          active_q,
  output logic [CW-1:0] cnt_q,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          pend_q, retrig_q, young_q;
  logic          active_d, pend_d, retrig_d, young_d;
  logic [CW-1:0] cnt_d;
  logic          pend_now;

  assign pend_now = pend_q | trig_ev;

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    retrig_d = retrig_q;
    young_d  = young_q;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (stop_p) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
      retrig_d = 1'b0;
      young_d  = 1'b0;
      cnt_d    = reload_q;
    end else if (ld_p) begin
      cnt_d  = ld_val;
      pend_d = 1'b0;
    end else if (!(run && os_en)) begin
      pend_d = 1'b0;
    end else if (!tick) begin
      pend_d = pend_now;
    end else if (!active_q) begin
      if (pend_now) begin
        active_d = 1'b1;
        young_d  = 1'b1;
        pend_d   = 1'b0;
      end
    end else if (retrig_q) begin
      cnt_d    = reload_q;
      retrig_d = 1'b0;
      young_d  = 1'b0;
      pend_d   = pend_now;
    end else begin
      young_d = 1'b0;
      pend_d  = 1'b0;
      if (pend_now && !young_q) begin
        cnt_d    = cnt_q - ONE;
        retrig_d = 1'b1;
        young_d  = 1'b1;
      end else if (cnt_q <= ONE) begin
        active_d = 1'b0;
        cnt_d    = reload_q;
        expire   = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      retrig_q <= 1'b0;
      young_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      retrig_q <= retrig_d;
      young_q  <= young_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/os_irq.sv
module os_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic stop_p,
  input  logic entry,
  input  logic clr,
  output logic irq_q
);
  logic stop_d;
  logic set_ev;

  assign set_ev = expire | stop_d | entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_d <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stop_d <= stop_p;
      if (set_ev)   irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/oneshot_chan.sv
module oneshot_chan import os_pkg::*; #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_reload,
  input  logic          cfg_ext_sel,
  input  logic          cfg_cut_en,
  input  logic          run_we,
  input  logic          run_val,
  input  logic          sw_trig,
  input  logic          irq_clr,
  input  logic          ext_trig,
  input  logic          shdn_n,
  output logic          pin_o,
  output logic          pin_oe,
  output logic          irq_o,
  output logic [CW-1:0] cnt_o
);
  os_mode_e      mode_q;
  logic [CW-1:0] reload_q;
  logic          ext_sel_q, cut_en_q, run_q, ld_p, stop_p, entry_q;
  logic          ext_s, ext_prev_q, ext_rise, shdn_s;
  logic          trig_ev, os_en, expire, active_q, oe_q;
  logic [CW-1:0] cnt_q;

  os_cfg #(.CW(CW)) u_cfg (
    .clk, .rst, .cfg_we, .cfg_mode, .cfg_reload, .cfg_ext_sel, .cfg_cut_en,
    .run_we, .run_val, .mode_q, .reload_q, .ext_sel_q, .cut_en_q, .run_q,
    .ld_p, .stop_p, .entry_q
  );

  os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
    .clk, .rst, .d(ext_trig), .q(ext_s)
  );

  os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_shdn_sync (
    .clk, .rst, .d(shdn_n), .q(shdn_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev_q <= 1'b0;
      oe_q       <= 1'b1;
    end else begin
      ext_prev_q <= ext_s;
      oe_q       <= ~(cut_en_q & ~shdn_s);
    end
  end

  assign ext_rise = ext_s & ~ext_prev_q;
  assign trig_ev  = ext_sel_q ? ext_rise : sw_trig;
  assign os_en    = (mode_q == MODE_ONESHOT);

  os_core #(.CW(CW)) u_core (
    .clk, .rst, .tick, .run(run_q), .os_en, .trig_ev, .stop_p, .ld_p,
    .ld_val(cfg_reload), .reload_q, .active_q, .cnt_q, .expire
  );

  os_irq u_irq (
    .clk, .rst, .expire, .stop_p, .entry(entry_q), .clr(irq_clr), .irq_q(irq_o)
  );

  assign pin_o  = active_q;
  assign pin_oe = oe_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/os_chk.sv
module os_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          cfg_we,
  input logic          run_q,
  input logic          cut_en_q,
  input logic          stop_p,
  input logic          expire,
  input logic          irq_clr,
  input logic [CW-1:0] reload_q,
  input logic [CW-1:0] cnt_o,
  input logic          pin_o,
  input logic          pin_oe,
  input logic          irq_o
);
  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_o) |-> $past(tick));

  // R5
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_o) |-> ($past(tick) || $past(stop_p)));

  // R6
  expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (irq_o && !pin_o));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (!pin_o && cnt_o == $past(reload_q)));

  // R9
  stop_irq_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> ##1 irq_o);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);

  // R2
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && cfg_we) |=> $stable(reload_q));

  // R13
  oe_free_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cut_en_q) |-> pin_oe);
endmodule

bind oneshot_chan os_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .run_q(run_q),
  .cut_en_q(cut_en_q), .stop_p(stop_p), .expire(expire), .irq_clr(irq_clr),
  .reload_q(reload_q), .cnt_o(cnt_o), .pin_o(pin_o), .pin_oe(pin_oe),
  .irq_o(irq_o)
);

// File: tb/oneshot_chan_test.sv
module oneshot_chan_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [CW-1:0] cfg_reload = '0;
  logic          cfg_ext_sel = 1'b0;
  logic          cfg_cut_en = 1'b0;
  logic          run_we = 1'b0;
  logic          run_val = 1'b0;
  logic          sw_trig = 1'b0;
  logic          irq_clr = 1'b0;
  logic          ext_trig = 1'b0;
  logic          shdn_n = 1'b1;
  logic          pin_o, pin_oe, irq_o;
  logic [CW-1:0] cnt_o;

  int checks = 0;
  int fails  = 0;
  int div    = 1;
  int tph    = 0;
  int run_len = 0, last_len = 0, pulses = 0;

  oneshot_chan #(.CW(CW)) uut (
    .clk, .rst, .tick, .cfg_we, .cfg_mode, .cfg_reload, .cfg_ext_sel,
    .cfg_cut_en, .run_we, .run_val, .sw_trig, .irq_clr, .ext_trig, .shdn_n,
    .pin_o, .pin_oe, .irq_o, .cnt_o
  );

  always #2.5 clk = ~clk;

  // count-source enable: one clock in every div
  initial forever begin
    @(negedge clk);
    tick = (tph == 0);
    tph  = (tph + 1 >= div) ? 0 : tph + 1;
  end

  // pulse-length monitor, sampled just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (pin_o) run_len++;
    else if (run_len > 0) begin
      last_len = run_len;
      pulses++;
      run_len = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] m, input int rl, input logic es, input logic ce);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_reload = CW'(rl);
    cfg_ext_sel = es; cfg_cut_en = ce;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic runbit(input logic v);
    @(negedge clk);
    run_we = 1'b1; run_val = v;
    @(negedge clk);
    run_we = 1'b0;
  endtask

  task automatic swt;
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic clr;
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic stop_clean;
    runbit(1'b0);
    cyc(3);
    clr();
  endtask

  task automatic wait_pulse(input int prev);
    for (int i = 0; i < 300; i++) begin
      if (pulses > prev) break;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    int rl;
    int dv;
    int k;
    int ext;
    int len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3, 1, 0, 0, 3},
    '{5, 1, 0, 1, 5},
    '{0, 1, 0, 0, 1},
    '{4, 3, 0, 0, 12},
    '{6, 1, 3, 0, 10},
    '{6, 1, 1, 0, 6},
    '{2, 1, 2, 0, 5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int prev;
    cyc(3);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 pin_o", int'(pin_o), 0);
    chk("R1 pin_oe", int'(pin_oe), 1);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 cnt", int'(cnt_o), 0);

    // R10: first entry into one-shot after reset (mode 0 -> 2)
    cfg(2'd2, 3, 1'b0, 1'b0);
    chk("R10 entry not yet", int'(irq_o), 0);
    @(negedge clk);
    chk("R10 entry from reset", int'(irq_o), 1);
    clr();

    // vector table walk: R5, R6, R7, R8, R12
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (VEC[v].k == 1) ? "R8" : (VEC[v].k > 1) ? "R7" :
            (VEC[v].ext != 0) ? "R12" : "R5";
      stop_clean();
      div = VEC[v].dv;
      cfg(2'd2, VEC[v].rl, VEC[v].ext[0], 1'b0);
      runbit(1'b1);
      cyc(3);
      prev = pulses;
      @(negedge clk);
      if (VEC[v].ext != 0) ext_trig = 1'b1;
      else sw_trig = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0;
      if (VEC[v].k > 0) begin
        repeat (VEC[v].k - 1) @(negedge clk);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
      end
      wait_pulse(prev);
      ext_trig = 1'b0;
      chk({tag, " pulse length"}, last_len, VEC[v].len);
      chk("R6 irq at expiry", int'(irq_o), 1);
      chk("R5 counter reloaded", int'(cnt_o), (VEC[v].rl == 0) ? 0 : VEC[v].rl);
      clr();
    end
    div = 1;

    // R4: same-cycle tick gives output one clock after the strobe
    stop_clean();
    cfg(2'd2, 4, 1'b0, 1'b0);
    runbit(1'b1);
    cyc(2);
    swt();
    chk("R4 output high next clock", int'(pin_o), 1);
    cyc(10);
    clr();

    // R2: writes while running are ignored
    cfg(2'd0, 9, 1'b1, 1'b1);
    chk("R2 counter kept", int'(cnt_o), 4);
    @(negedge clk);
    chk("R2 no mode entry irq", int'(irq_o), 0);
    prev = pulses;
    swt();
    cyc(12);
    chk("R2 still triggers by sw", pulses, prev + 1);
    chk("R2 old reload used", last_len, 4);
    clr();

    // R3: unselected source, stopped, other mode
    prev = pulses;
    @(negedge clk) ext_trig = 1'b1;
    cyc(8);
    ext_trig = 1'b0;
    cyc(4);
    chk("R3 ext ignored when sw selected", pulses, prev);
    chk("R3 output low", int'(pin_o), 0);
    stop_clean();
    swt();
    cyc(8);
    chk("R3 trigger while stopped", pulses, prev);
    cfg(2'd2, 4, 1'b1, 1'b0);
    runbit(1'b1);
    swt();
    cyc(8);
    chk("R3 sw ignored when ext selected", pulses, prev);
    stop_clean();
    cfg(2'd1, 4, 1'b0, 1'b0);
    runbit(1'b1);
    swt();
    cyc(8);
    chk("R3 trigger in event mode", pulses, prev);

    // R10: entry from event mode, none from PWM or from one-shot itself
    stop_clean();
    cfg(2'd2, 3, 1'b0, 1'b0);
    chk("R10 event entry not yet", int'(irq_o), 0);
    @(negedge clk);
    chk("R10 entry from event", int'(irq_o), 1);
    clr();
    cfg(2'd2, 3, 1'b0, 1'b0);
    cyc(3);
    chk("R10 rewrite of one-shot", int'(irq_o), 0);
    cfg(2'd3, 3, 1'b0, 1'b0);
    cfg(2'd2, 3, 1'b0, 1'b0);
    cyc(3);
    chk("R10 from pwm", int'(irq_o), 0);

    // R12: held external level gives one pulse
    cfg(2'd2, 3, 1'b1, 1'b0);
    runbit(1'b1);
    prev = pulses;
    @(negedge clk) ext_trig = 1'b1;
    cyc(30);
    chk("R12 single pulse for held level", pulses, prev + 1);
    ext_trig = 1'b0;
    cyc(3);
    clr();

    // R9: stop during a pulse
    stop_clean();
    cfg(2'd2, 8, 1'b0, 1'b0);
    runbit(1'b1);
    swt();
    cyc(2);
    chk("R9 pulse running", int'(pin_o), 1);
    runbit(1'b0);
    chk("R9 output low", int'(pin_o), 0);
    chk("R9 counter reloaded", int'(cnt_o), 8);
    chk("R9 irq not yet", int'(irq_o), 0);
    @(negedge clk);
    chk("R9 irq one clock later", int'(irq_o), 1);

    // R11: clear, then set and clear together
    clr();
    chk("R11 cleared", int'(irq_o), 0);
    runbit(1'b1);
    @(negedge clk);
    run_we = 1'b1; run_val = 1'b0;
    @(negedge clk);
    run_we = 1'b0; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R11 set wins over clear", int'(irq_o), 1);
    cyc(2);
    chk("R11 holds without clear", int'(irq_o), 1);
    clr();

    // R13: forced cutoff
    cfg(2'd2, 3, 1'b0, 1'b1);
    @(negedge clk) shdn_n = 1'b0;
    cyc(2);
    chk("R13 oe before three clocks", int'(pin_oe), 1);
    cyc(1);
    chk("R13 oe cut", int'(pin_oe), 0);
    shdn_n = 1'b1;
    cyc(4);
    chk("R13 oe restored", int'(pin_oe), 1);
    cfg(2'd2, 3, 1'b0, 1'b0);
    shdn_n = 1'b0;
    cyc(5);
    chk("R13 cutoff disabled", int'(pin_oe), 1);
    shdn_n = 1'b1;
    cyc(2);

    summary();
  end
endmodule